// File: doc/BRIEF.md
# Register-Array Q-Learning Agent

This block is a self-contained tabular Q-learning agent for small problems with N states and Z actions. Every state-action value is held in its own signed register, so no memory is involved. The environment is built in as constant tables. From state s, action a leads to state (s + a) mod N. Each pair also has a fixed reward. A pseudo-random generator draws actions. The agent never consults its Q-values to choose what to do.

After a `start` pulse the agent loads a seed into its generator and draws a random start state. From then on it tries to take one step per clock cycle. In a step it draws an action, looks up the reward and the next state, and forms the target: the reward plus the largest Q-value of the next state, scaled by gamma. It then moves the enabled Q register a fraction alpha of the way towards that target, and advances to the next state. On reaching the goal state it draws a new random start state. Gamma and alpha are powers of two and are applied as arithmetic right shifts.

The block has no stream data path. All pins are plain control or observation signals. The step outputs are combinational and describe the update that takes effect at the coming clock edge. A combinational read port returns any stored Q-value.

Top module: `qla_agent`

## Requirements
- R1: A `start` pulse loads the generator with `seed`, or with 16'h0001 if `seed` is zero, and sets `seeking`. While seeking, the top SW bits of the generator give a candidate state. The candidate is accepted into `cur_state` only if it is below N and is not GOAL. Acceptance clears `seeking`. No step is made in the cycle where `start` is high.
- R2: The generator is a 16-bit LFSR that shifts towards the MSB. Bit 0 receives bit15 ^ bit13 ^ bit12 ^ bit10, for the polynomial x^16+x^14+x^13+x^11+1. It advances once per cycle while the agent is active.
- R3: The drawn action is the low AW bits of the generator. A step occurs only when the agent is not seeking and the drawn value is below Z. Otherwise the value is rejected and `step_valid` stays low for that cycle.
- R4: During a step, `upd_en` has exactly one bit set, at index state*Z + action. In all other cycles it is zero.
- R5: During a step, `step_next` is (state + action) mod N. `step_reward` is R_GOAL if that next state is GOAL, otherwise R_BAD if the action is 0, otherwise 0.
- R6: A step writes only the enabled Q register. The new value is sat16(q + ((reward + (max_a Q[next][a] >>> GAMMA_SHIFT)) - q) >>> ALPHA_SHIFT), where sat16 clamps to the signed 16-bit range. All other Q registers keep their values.
- R7: At the clock edge that ends a step, `cur_state` takes the value of `step_next`.
- R8: A step whose next state is GOAL sets `seeking`, so that a new start state is drawn in the following cycles.
- R9: After reset the agent is idle: every Q-value is 0, `cur_state` is 0, `seeking` is 1, and `step_valid` and `upd_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load seed and begin a new run |
| seed | input | 16 | Generator seed |
| q_rd_state | input | SW | Read port state index |
| q_rd_action | input | AW | Read port action index |
| q_rd_data | output | QW | Q-value at the read index (0 if out of range) |
| cur_state | output | SW | Current state |
| seeking | output | 1 | Drawing a start state |
| step_valid | output | 1 | An update is made at the coming edge |
| step_action | output | AW | Drawn action |
| step_next | output | SW | Next state for the step |
| step_reward | output | QW | Reward for the step |
| upd_en | output | N*Z | One-hot update enable |

## Verification
The assertions check every cycle that the update enable is one-hot during a step and zero otherwise. They also check that a step's action is below Z, that Q registers which are not enabled keep their value, that the state follows `step_next`, that reaching the goal sets `seeking`, and that an accepted start state is legal. Only the bench scenarios can show the exact random sequence, the rejection pattern, the reward values and the updated Q arithmetic. The bench shows these by running its own generator, environment and shadow Q table over thousands of steps, across two seeds including zero.

// File: rtl/qla_pkg.sv
package qla_pkg;
  // Environment transition: action a moves a steps forward on a ring of n states.
  function automatic int env_next(int s, int a, int n);
    return (s + a) % n;
  endfunction

  // Environment reward: goal arrival positive, standing still penalised.
  function automatic int env_reward(int s, int a, int n, int goal, int rpos, int rneg);
    if (env_next(s, a, n) == goal) return rpos;
    if (a == 0) return rneg;
    return 0;
  endfunction
endpackage

// File: rtl/qla_rng.sv
module qla_rng (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [15:0] seed,
  input  logic        advance,
  output logic [15:0] value
);
  logic fb;
  assign fb = value[15] ^ value[13] ^ value[12] ^ value[10];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        value <= 16'h0001;
    else if (load)     value <= (seed == 16'h0000) ? 16'h0001 : seed;
    else if (advance)  value <= {value[14:0], fb};
  end

  assert_lfsr_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    value != 16'h0000);
endmodule

// File: rtl/qla_cell.sv
module qla_cell import qla_pkg::*; #(
  parameter int N   = 6,
  parameter int Z   = 3,
  parameter int QW  = 16,
  parameter int SW  = 3,
  parameter int AW  = 2,
  parameter int AS  = 2,
  parameter int SID = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [Z-1:0]         wr_en,
  input  logic [AW-1:0]        act,
  input  logic signed [QW+1:0] target,
  output logic signed [QW-1:0] row_max,
  output logic [SW-1:0]        nxt,
  output logic [Z*QW-1:0]      q_flat
);
  localparam int XW   = QW + 3;
  localparam int QMAX = (1 << (QW - 1)) - 1;
  localparam int QMIN = -(1 << (QW - 1));

  logic signed [QW-1:0] q     [Z];
  logic [SW-1:0]        ns    [Z];
  logic signed [XW-1:0] sum_a [Z];
  logic signed [QW-1:0] cand  [Z];

  for (genvar a = 0; a < Z; a++) begin : g_act
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ns[a] <= SW'(env_next(SID, a, N));
      else               ns[a] <= ns[a];
    end

    always_comb begin
      logic signed [XW-1:0] diff;
      diff     = XW'(target) - XW'(q[a]);
      sum_a[a] = XW'(q[a]) + (diff >>> AS);
      if (sum_a[a] > $signed(XW'(QMAX)))      cand[a] = QW'(QMAX);
      else if (sum_a[a] < $signed(XW'(QMIN))) cand[a] = QW'(QMIN);
      else                                    cand[a] = sum_a[a][QW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q[a] <= '0;
      else if (wr_en[a])  q[a] <= cand[a];
    end

    assign q_flat[a*QW +: QW] = q[a];

    assert_idle_q_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en[a] |=> $stable(q[a]));
  end

  always_comb begin
    row_max = q[0];
    for (int a = 1; a < Z; a++)
      if (q[a] > row_max) row_max = q[a];
  end

  always_comb begin
    nxt = '0;
    for (int a = 0; a < Z; a++)
      if (32'(act) == a) nxt = ns[a];
  end
endmodule

// File: rtl/qla_select.sv
module qla_select #(
  parameter int N  = 6,
  parameter int QW = 16,
  parameter int SW = 3,
  parameter int GS = 1
) (
  input  logic [N*QW-1:0]       row_max_flat,
  input  logic [N*SW-1:0]       nxt_flat,
  input  logic [SW-1:0]         cur,
  input  logic signed [QW-1:0]  reward,
  output logic [SW-1:0]         next,
  output logic signed [QW+1:0]  target
);
  logic signed [QW-1:0] qmax;

  always_comb begin
    next = '0;
    qmax = '0;
    for (int s = 0; s < N; s++)
      if (32'(cur) == s) next = nxt_flat[s*SW +: SW];
    for (int s = 0; s < N; s++)
      if (32'(next) == s) qmax = row_max_flat[s*QW +: QW];
    target = (QW+2)'(reward) + (QW+2)'(qmax >>> GS);
  end
endmodule

// File: rtl/qla_agent.sv
module qla_agent import qla_pkg::*; #(
  parameter int N_STATES    = 6,
  parameter int N_ACTIONS   = 3,
  parameter int GOAL        = 5,
  parameter int QW          = 16,
  parameter int ALPHA_SHIFT = 2,
  parameter int GAMMA_SHIFT = 1,
  parameter int R_GOAL      = 100,
  parameter int R_BAD       = -10,
  localparam int SW = $clog2(N_STATES),
  localparam int AW = $clog2(N_ACTIONS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [15:0]              seed,
  input  logic [SW-1:0]            q_rd_state,
  input  logic [AW-1:0]            q_rd_action,
  output logic signed [QW-1:0]     q_rd_data,
  output logic [SW-1:0]            cur_state,
  output logic                     seeking,
  output logic                     step_valid,
  output logic [AW-1:0]            step_action,
  output logic [SW-1:0]            step_next,
  output logic signed [QW-1:0]     step_reward,
  output logic [N_STATES*N_ACTIONS-1:0] upd_en
);
  localparam int N = N_STATES;
  localparam int Z = N_ACTIONS;

  logic                 active;
  logic [15:0]          rnd;
  logic [AW-1:0]        draw;
  logic [SW-1:0]        cand;
  logic                 draw_ok, cand_ok;
  logic [N*QW-1:0]      row_max_flat;
  logic [N*SW-1:0]      nxt_flat;
  logic [N*Z*QW-1:0]    q_all;
  logic signed [QW+1:0] target;
  logic signed [QW-1:0] rew_tbl [N][Z];

  qla_rng u_rng (
    .clk(clk), .rst_n(rst_n), .load(start), .seed(seed),
    .advance(active), .value(rnd)
  );

  assign draw       = rnd[AW-1:0];
  assign cand       = rnd[15 -: SW];
  assign draw_ok    = 32'(draw) < Z;
  assign cand_ok    = (32'(cand) < N) && (32'(cand) != GOAL);
  assign step_valid = active && !seeking && draw_ok && !start;
  assign step_action = draw;

  for (genvar s = 0; s < N; s++) begin : g_state
    for (genvar a = 0; a < Z; a++) begin : g_pair
      assign rew_tbl[s][a] = QW'(env_reward(s, a, N, GOAL, R_GOAL, R_BAD));
      assign upd_en[s*Z+a] = step_valid && (32'(cur_state) == s) && (32'(draw) == a);
    end

    qla_cell #(
      .N(N), .Z(Z), .QW(QW), .SW(SW), .AW(AW), .AS(ALPHA_SHIFT), .SID(s)
    ) u_cell (
      .clk(clk), .rst_n(rst_n),
      .wr_en(upd_en[s*Z +: Z]),
      .act(draw),
      .target(target),
      .row_max(row_max_flat[s*QW +: QW]),
      .nxt(nxt_flat[s*SW +: SW]),
      .q_flat(q_all[s*Z*QW +: Z*QW])
    );
  end

  always_comb begin
    step_reward = '0;
    for (int s = 0; s < N; s++)
      for (int a = 0; a < Z; a++)
        if (step_valid && 32'(cur_state) == s && 32'(draw) == a)
          step_reward = rew_tbl[s][a];
  end

  qla_select #(.N(N), .QW(QW), .SW(SW), .GS(GAMMA_SHIFT)) u_sel (
    .row_max_flat(row_max_flat), .nxt_flat(nxt_flat), .cur(cur_state),
    .reward(step_reward), .next(step_next), .target(target)
  );

  always_comb begin
    q_rd_data = '0;
    for (int s = 0; s < N; s++)
      for (int a = 0; a < Z; a++)
        if (32'(q_rd_state) == s && 32'(q_rd_action) == a)
          q_rd_data = q_all[(s*Z+a)*QW +: QW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      seeking   <= 1'b1;
      cur_state <= '0;
    end else if (start) begin
      active    <= 1'b1;
      seeking   <= 1'b1;
    end else if (active) begin
      if (seeking) begin
        if (cand_ok) begin
          cur_state <= cand;
          seeking   <= 1'b0;
        end
      end else if (step_valid) begin
        cur_state <= step_next;
        if (32'(step_next) == GOAL) seeking <= 1'b1;
      end
    end
  end

  assert_onehot_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid ? ($countones(upd_en) == 1) : (upd_en == '0));
  assert_action_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid |-> (32'(step_action) < Z));
  assert_state_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid |=> (cur_state == $past(step_next)));
  assert_goal_seek_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && 32'(step_next) == GOAL) |=> seeking);
  assert_start_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seeking) |-> ((32'(cur_state) < N) && (32'(cur_state) != GOAL)));
endmodule

// File: tb/tb_qla_agent.sv
module tb_qla_agent;
  localparam int N = 6, Z = 3, GOAL = 5, RPOS = 100, RNEG = -10;
  localparam int AS = 2, GS = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] seed = 16'h0;
  logic [2:0] q_rd_state = '0;
  logic [1:0] q_rd_action = '0;
  logic signed [15:0] q_rd_data, step_reward;
  logic [2:0] cur_state, step_next;
  logic seeking, step_valid;
  logic [1:0] step_action;
  logic [17:0] upd_en;

  always #10 clk = ~clk;

  qla_agent dut (
    .clk(clk), .rst_n(rst_n), .start(start), .seed(seed),
    .q_rd_state(q_rd_state), .q_rd_action(q_rd_action), .q_rd_data(q_rd_data),
    .cur_state(cur_state), .seeking(seeking), .step_valid(step_valid),
    .step_action(step_action), .step_next(step_next), .step_reward(step_reward),
    .upd_en(upd_en)
  );

  int checks = 0, fails = 0;
  int shadow [N][Z];
  logic [15:0] m_lfsr;
  bit m_seek;
  int m_state;
  bit pend = 0;
  int pend_exp;
  int goals = 0, rejects = 0, steps = 0, reloads = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lfsr_next(logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  function automatic int sat16(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic do_start(logic [15:0] sd);
    @(negedge clk);
    if (pend) begin chk("R6 q update", int'(q_rd_data), pend_exp); pend = 0; end
    seed = sd; start = 1'b1;
    #1;
    chk("R1 no step during start", int'(step_valid), 0);
    @(posedge clk);
    m_lfsr = (sd == 16'h0) ? 16'h0001 : sd;
    m_seek = 1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(int cycles);
    for (int c = 0; c < cycles; c++) begin
      int d, cand, ns, rw, qmax, tgt, nq;
      if (c != 0) @(negedge clk);
      if (pend) begin chk("R6 q update", int'(q_rd_data), pend_exp); pend = 0; end
      chk("R7 cur_state", int'(cur_state), m_state);
      chk("R8 seeking", int'(seeking), int'(m_seek));
      d = int'(m_lfsr[1:0]);
      cand = int'(m_lfsr[15:13]);
      if (!m_seek && d < Z) begin
        ns = (m_state + d) % N;
        rw = (ns == GOAL) ? RPOS : ((d == 0) ? RNEG : 0);
        chk("R3 step_valid", int'(step_valid), 1);
        chk("R3 step_action", int'(step_action), d);
        chk("R5 step_next", int'(step_next), ns);
        chk("R5 step_reward", int'(step_reward), rw);
        chk("R4 upd_en onehot", int'(upd_en == (18'd1 << (m_state*Z + d))), 1);
        qmax = shadow[ns][0];
        for (int a = 1; a < Z; a++) if (shadow[ns][a] > qmax) qmax = shadow[ns][a];
        tgt = rw + (qmax >>> GS);
        nq = sat16(shadow[m_state][d] + ((tgt - shadow[m_state][d]) >>> AS));
        shadow[m_state][d] = nq;
        q_rd_state = 3'(m_state); q_rd_action = 2'(d);
        pend = 1; pend_exp = nq;
        steps++;
        m_state = ns;
        if (ns == GOAL) begin m_seek = 1; goals++; end
      end else begin
        chk("R3 no step", int'(step_valid), 0);
        chk("R4 upd_en idle", int'(upd_en), 0);
        if (!m_seek) rejects++;
        if (m_seek && cand < N && cand != GOAL) begin
          m_state = cand; m_seek = 0; reloads++;
        end
      end
      m_lfsr = lfsr_next(m_lfsr);
      @(posedge clk);
    end
  endtask

  initial begin
    for (int s = 0; s < N; s++) for (int a = 0; a < Z; a++) shadow[s][a] = 0;
    m_state = 0; m_seek = 1; m_lfsr = 16'h0001;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 cur_state", int'(cur_state), 0);
    chk("R9 seeking", int'(seeking), 1);
    chk("R9 step_valid", int'(step_valid), 0);
    chk("R9 upd_en", int'(upd_en), 0);
    for (int s = 0; s < N; s++)
      for (int a = 0; a < Z; a++) begin
        q_rd_state = 3'(s); q_rd_action = 2'(a);
        #1 chk("R9 q zero", int'(q_rd_data), 0);
      end
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle after reset", int'(step_valid), 0);
    do_start(16'hACE1);   // R1 R2
    run(3000);
    do_start(16'h0000);   // R1 zero seed maps to 1
    run(3000);
    @(negedge clk);
    if (pend) begin chk("R6 q update", int'(q_rd_data), pend_exp); pend = 0; end
    chk("R3 rejections seen", int'(rejects > 0), 1);
    chk("R8 goal reached", int'(goals > 0), 1);
    chk("R1 reload seen", int'(reloads > 1), 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule